// File: doc/BRIEF.md
# Preloaded Raster Timing Generator

This block produces the horizontal and vertical scan timing for a raster display from one free-running clock and a pixel-clock enable. Each axis has a counter. During the active picture it counts a power-of-two span of elements or lines. After that span its top bit sets, and that bit is the blanking flag for the axis. The retrace interval is not ended by comparing the count with a terminal value. When the counter enters blanking, its lower bits are reloaded with a higher start value, so the same wrap of the lower bits ends a shorter pass.

Downstream logic takes the full element and line counts. The lower bits address display memory in cells, and the upper bits pick the row inside a character. The block also drives the two blanking flags, two sync pulses that sit inside blanking, and a one-cycle line strobe. The vertical counter advances on that strobe.

Top module: `rtg_raster_timing`

## Requirements
- R1: A synchronous active-high reset sets both counts to zero, both blank flags low, both sync outputs inactive and the line strobe low. All of this is visible at the first clock edge after reset is released, and reset takes priority over the enable.
- R2: On a clock edge where the pixel enable is low, the element count and the line count keep their values.
- R3: From zero, the element count steps by one on each enabled edge up to 255 with the horizontal blank flag low. The next enabled edge sets bit 8 of the count. That bit is the horizontal blank flag. The same edge loads the low 8 bits with 256 minus the horizontal retrace length, which is 192 by default.
- R4: During horizontal blanking the low 8 bits step up to 255. The enabled edge at count 511 returns the element count to 0 with the flag low. A line is therefore 256 + H_RETRACE enabled edges long, which is 320 by default.
- R5: The line strobe is high in exactly the cycles where the pixel enable is high and the element count is 511. It is combinational, so it lasts one enabled cycle.
- R6: The line count changes only on edges where the line strobe is high. It follows the same scheme with V_RETRACE, which is 8 by default. Lines 0 to 255 are active. Then bit 8 (the vertical blank flag) sets and the low bits are loaded with 248. Count 511 returns to 0, which gives 264 lines per frame.
- R7: Horizontal sync is active when horizontal blank is high and the blank offset (low 8 bits minus the preload) is at least HS_START and less than HS_START + HS_LEN. The defaults are 8 and 24. The sync is active high when SYNC_HIGH = 1.
- R8: Vertical sync is active when vertical blank is high and the line blank offset is at least VS_START and less than VS_START + VS_LEN. The defaults are 2 and 3. It uses the same polarity parameter as horizontal sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Element clock enable |
| elem_cnt | output | ACT_BITS+1 | Element count; top bit is horizontal blank |
| line_cnt | output | ACT_BITS+1 | Line count; top bit is vertical blank |
| h_blank | output | 1 | Horizontal blanking in progress |
| v_blank | output | 1 | Vertical blanking in progress |
| h_sync | output | 1 | Horizontal sync pulse |
| v_sync | output | 1 | Vertical sync pulse |
| line_tick | output | 1 | One-cycle strobe at the end of horizontal retrace |

## Verification
Suppose a preload value or a wrap point is wrong in one of the counters. The element count then leaves the reference sequence on the first enabled edge at the bad boundary. That is at most 320 enabled cycles after reset. A fault in the line counter or the vertical sync window can only show at a line boundary. Such a fault therefore appears within one frame of 84,480 enabled cycles, as a wrong line count, a wrong vertical blank flag or a wrong vertical sync. The bench runs one whole frame with the enable held high and a second stretch with a random enable. Because of this, faults in the enable gating also show on the first cycle where the enable is low.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   // Start value loaded into the low bits when a counter enters blanking.
   function automatic int unsigned blank_preload(input int unsigned act_bits,
                                                 input int unsigned retrace);
      return (int'(1) << act_bits) - retrace;
   endfunction

   // Whether a sync window fits inside the retrace interval.
   function automatic bit window_fits(input int unsigned start,
                                      input int unsigned len,
                                      input int unsigned retrace);
      return (len >= 1) && (start + len <= retrace);
   endfunction

endpackage

// File: rtl/rtg_preload_counter.sv
module rtg_preload_counter
   import rtg_pkg::*;
#(
   parameter int unsigned ACT_BITS = 8,
   parameter int unsigned RETRACE  = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   output logic [ACT_BITS:0] cnt,
   output logic              at_end
);
   localparam int unsigned PRE_INT = blank_preload(ACT_BITS, RETRACE);
   localparam logic [ACT_BITS-1:0] PRE = ACT_BITS'(PRE_INT);

   logic                blank_q;
   logic [ACT_BITS-1:0] low_q;
   logic                low_full;

   assign low_full = &low_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         blank_q <= 1'b0;
         low_q   <= '0;
      end else if (step) begin
         if (low_full) begin
            blank_q <= ~blank_q;
            low_q   <= blank_q ? '0 : PRE;
         end else begin
            low_q   <= low_q + 1'b1;
         end
      end
   end

   assign cnt    = {blank_q, low_q};
   assign at_end = blank_q & low_full;

endmodule

// File: rtl/rtg_sync_window.sv
module rtg_sync_window
   import rtg_pkg::*;
#(
   parameter int unsigned ACT_BITS  = 8,
   parameter int unsigned RETRACE   = 64,
   parameter int unsigned WIN_START = 8,
   parameter int unsigned WIN_LEN   = 24,
   parameter bit          SYNC_HIGH = 1'b1
) (
   input  logic [ACT_BITS:0] cnt,
   output logic              sync
);
   localparam logic [ACT_BITS-1:0] PRE    = ACT_BITS'(blank_preload(ACT_BITS, RETRACE));
   localparam logic [ACT_BITS:0]   W_LO   = (ACT_BITS+1)'(WIN_START);
   localparam logic [ACT_BITS:0]   W_HI   = (ACT_BITS+1)'(WIN_START + WIN_LEN);

   logic [ACT_BITS-1:0] offset;
   logic [ACT_BITS:0]   offset_x;
   logic                in_win;

   assign offset   = cnt[ACT_BITS-1:0] - PRE;
   assign offset_x = {1'b0, offset};
   assign in_win   = cnt[ACT_BITS] && (offset_x >= W_LO) && (offset_x < W_HI);

   generate
      if (SYNC_HIGH) begin : g_pos
         assign sync = in_win;
      end else begin : g_neg
         assign sync = ~in_win;
      end
   endgenerate

endmodule

// File: rtl/rtg_raster_timing.sv
module rtg_raster_timing
   import rtg_pkg::*;
#(
   parameter int unsigned ACT_BITS  = 8,
   parameter int unsigned H_RETRACE = 64,
   parameter int unsigned V_RETRACE = 8,
   parameter int unsigned HS_START  = 8,
   parameter int unsigned HS_LEN    = 24,
   parameter int unsigned VS_START  = 2,
   parameter int unsigned VS_LEN    = 3,
   parameter bit          SYNC_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pix_en,
   output logic [ACT_BITS:0] elem_cnt,
   output logic [ACT_BITS:0] line_cnt,
   output logic              h_blank,
   output logic              v_blank,
   output logic              h_sync,
   output logic              v_sync,
   output logic              line_tick
);
   localparam int unsigned SPAN = 1 << ACT_BITS;

   generate
      if (ACT_BITS < 2 || ACT_BITS > 16) begin : g_bad_bits
         $error("rtg_raster_timing: ACT_BITS out of range");
      end
      if (H_RETRACE < 1 || H_RETRACE > SPAN) begin : g_bad_hret
         $error("rtg_raster_timing: H_RETRACE out of range");
      end
      if (V_RETRACE < 1 || V_RETRACE > SPAN) begin : g_bad_vret
         $error("rtg_raster_timing: V_RETRACE out of range");
      end
      if (!window_fits(HS_START, HS_LEN, H_RETRACE)) begin : g_bad_hs
         $error("rtg_raster_timing: horizontal sync window outside retrace");
      end
      if (!window_fits(VS_START, VS_LEN, V_RETRACE)) begin : g_bad_vs
         $error("rtg_raster_timing: vertical sync window outside retrace");
      end
   endgenerate

   logic h_end;
   logic v_end_unused;
   logic h_step;

   assign h_step = pix_en;

   rtg_preload_counter #(.ACT_BITS(ACT_BITS), .RETRACE(H_RETRACE)) u_hcnt (
      .clk    (clk),
      .rst    (rst),
      .step   (h_step),
      .cnt    (elem_cnt),
      .at_end (h_end)
   );

   assign line_tick = pix_en & h_end;

   rtg_preload_counter #(.ACT_BITS(ACT_BITS), .RETRACE(V_RETRACE)) u_vcnt (
      .clk    (clk),
      .rst    (rst),
      .step   (line_tick),
      .cnt    (line_cnt),
      .at_end (v_end_unused)
   );

   assign h_blank = elem_cnt[ACT_BITS];
   assign v_blank = line_cnt[ACT_BITS];

   rtg_sync_window #(
      .ACT_BITS(ACT_BITS), .RETRACE(H_RETRACE),
      .WIN_START(HS_START), .WIN_LEN(HS_LEN), .SYNC_HIGH(SYNC_HIGH)
   ) u_hsync (
      .cnt  (elem_cnt),
      .sync (h_sync)
   );

   rtg_sync_window #(
      .ACT_BITS(ACT_BITS), .RETRACE(V_RETRACE),
      .WIN_START(VS_START), .WIN_LEN(VS_LEN), .SYNC_HIGH(SYNC_HIGH)
   ) u_vsync (
      .cnt  (line_cnt),
      .sync (v_sync)
   );

endmodule

// File: rtl/rtg_raster_checker.sv
module rtg_raster_checker
   import rtg_pkg::*;
#(
   parameter int unsigned ACT_BITS  = 8,
   parameter int unsigned H_RETRACE = 64,
   parameter int unsigned V_RETRACE = 8,
   parameter bit          SYNC_HIGH = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              pix_en,
   input logic [ACT_BITS:0] elem_cnt,
   input logic [ACT_BITS:0] line_cnt,
   input logic              h_blank,
   input logic              v_blank,
   input logic              h_sync,
   input logic              v_sync,
   input logic              line_tick
);
   localparam logic [ACT_BITS-1:0] HPRE = ACT_BITS'(blank_preload(ACT_BITS, H_RETRACE));
   localparam logic [ACT_BITS:0]   LAST_ACT = {1'b0, {ACT_BITS{1'b1}}};

   logic hs_on, vs_on;
   assign hs_on = SYNC_HIGH ? h_sync : ~h_sync;
   assign vs_on = SYNC_HIGH ? v_sync : ~v_sync;

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (elem_cnt == '0) && (line_cnt == '0) && !h_blank && !v_blank);

   a_r2_elem_hold: assert property (@(posedge clk) disable iff (rst)
      !pix_en |=> $stable(elem_cnt));

   a_r3_enter_blank: assert property (@(posedge clk) disable iff (rst)
      (pix_en && elem_cnt == LAST_ACT) |=> (h_blank && elem_cnt[ACT_BITS-1:0] == HPRE));

   a_r4_leave_blank: assert property (@(posedge clk) disable iff (rst)
      (pix_en && h_blank && (&elem_cnt[ACT_BITS-1:0])) |=> (!h_blank && elem_cnt == '0));

   a_r5_tick_single: assert property (@(posedge clk) disable iff (rst)
      line_tick |=> !line_tick);

   a_r6_line_moves: assert property (@(posedge clk) disable iff (rst)
      line_tick |=> (line_cnt != $past(line_cnt)));

   a_r6_line_hold: assert property (@(posedge clk) disable iff (rst)
      !line_tick |=> $stable(line_cnt));

   a_r7_hsync_in_blank: assert property (@(posedge clk) disable iff (rst)
      hs_on |-> h_blank);

   a_r8_vsync_in_blank: assert property (@(posedge clk) disable iff (rst)
      vs_on |-> v_blank);

endmodule

bind rtg_raster_timing rtg_raster_checker #(
   .ACT_BITS(ACT_BITS), .H_RETRACE(H_RETRACE),
   .V_RETRACE(V_RETRACE), .SYNC_HIGH(SYNC_HIGH)
) u_rtg_chk (
   .clk       (clk),
   .rst       (rst),
   .pix_en    (pix_en),
   .elem_cnt  (elem_cnt),
   .line_cnt  (line_cnt),
   .h_blank   (h_blank),
   .v_blank   (v_blank),
   .h_sync    (h_sync),
   .v_sync    (v_sync),
   .line_tick (line_tick)
);

// File: tb/tb_rtg_raster_timing.sv
module tb_rtg_raster_timing;
   localparam int ACT  = 256;
   localparam int HRET = 64;
   localparam int VRET = 8;
   localparam int HTOT = ACT + HRET;
   localparam int VTOT = ACT + VRET;
   localparam int HPRE = ACT - HRET;
   localparam int VPRE = ACT - VRET;
   localparam int HS0 = 8,  HSL = 24;
   localparam int VS0 = 2,  VSL = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pix_en = 1'b0;
   logic [8:0] elem_cnt, line_cnt;
   logic       h_blank, v_blank, h_sync, v_sync, line_tick;

   int tests = 0;
   int fails = 0;
   int hpos = 0;
   int vpos = 0;
   bit checking = 1'b0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rtg_raster_timing dut (
      .clk(clk), .rst(rst), .pix_en(pix_en),
      .elem_cnt(elem_cnt), .line_cnt(line_cnt),
      .h_blank(h_blank), .v_blank(v_blank),
      .h_sync(h_sync), .v_sync(v_sync), .line_tick(line_tick)
   );

   // Behavioural reference: positions along the line and down the frame.
   always @(posedge clk) begin
      if (rst) begin
         hpos = 0;
         vpos = 0;
      end else if (pix_en) begin
         if (hpos == HTOT - 1) begin
            hpos = 0;
            vpos = (vpos == VTOT - 1) ? 0 : vpos + 1;
         end else begin
            hpos = hpos + 1;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d t=%0t)",
                  tag, act, exp, hpos, vpos, $time);
      end
   endtask

   function automatic int cnt_of(input int pos, input int pre);
      return (pos < ACT) ? pos : pos + pre;
   endfunction

   always @(negedge clk) begin
      if (checking && !rst) begin
         int hb, vb, hoff, voff;
         hb   = (hpos >= ACT) ? 1 : 0;
         vb   = (vpos >= ACT) ? 1 : 0;
         hoff = hpos - ACT;
         voff = vpos - ACT;
         chk(pix_en ? "R3/R4 elem_cnt" : "R2 elem_cnt held", int'(elem_cnt), cnt_of(hpos, HPRE));
         chk("R3 h_blank", int'(h_blank), hb);
         chk("R6 line_cnt", int'(line_cnt), cnt_of(vpos, VPRE));
         chk("R6 v_blank", int'(v_blank), vb);
         chk("R5 line_tick", int'(line_tick), (pix_en && hpos == HTOT - 1) ? 1 : 0);
         chk("R7 h_sync", int'(h_sync), (hb && hoff >= HS0 && hoff < HS0 + HSL) ? 1 : 0);
         chk("R8 v_sync", int'(v_sync), (vb && voff >= VS0 && voff < VS0 + VSL) ? 1 : 0);
      end
   end

   task automatic do_reset();
      checking = 1'b0;
      @(posedge clk); #1;
      rst = 1'b1;
      pix_en = 1'b1;              // reset must win over the enable
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      pix_en = 1'b0;
      @(negedge clk);
      // R1: state right after reset release
      chk("R1 elem_cnt", int'(elem_cnt), 0);
      chk("R1 line_cnt", int'(line_cnt), 0);
      chk("R1 h_blank", int'(h_blank), 0);
      chk("R1 v_blank", int'(v_blank), 0);
      chk("R1 h_sync", int'(h_sync), 0);
      chk("R1 v_sync", int'(v_sync), 0);
      chk("R1 line_tick", int'(line_tick), 0);
      checking = 1'b1;
   endtask

   initial begin
      do_reset();
      // One full frame plus some lines with the enable held high.
      for (int i = 0; i < HTOT * VTOT + 3 * HTOT; i++) begin
         @(posedge clk); #1;
         pix_en = 1'b1;
      end
      // Reset in the middle of a frame, then a random enable.
      do_reset();
      for (int i = 0; i < 60000; i++) begin
         @(posedge clk); #1;
         pix_en = ($urandom % 4) != 0;
      end
      @(posedge clk); #1;
      pix_en = 1'b0;
      @(negedge clk);
      checking = 1'b0;
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule